// File: doc/BRIEF.md
# Raster position interrupt timer

This block tracks the beam position of a video frame with a horizontal dot counter and a vertical line counter, both advanced by a dot-clock enable. From that position it raises two interrupt requests toward a processor. The first is a frame interrupt at the start of vertical blank. The second is a programmable raster interrupt that fires when the beam reaches a chosen dot, a chosen line, or a chosen dot on a chosen line.

Software programs the block through byte-wide register writes. These set an enable byte and two 9-bit trigger positions, each written as a low byte plus a high byte. Software reads three status bytes. Two of them hold the event flags, and reading either one acknowledges its own flag. The third shows live horizontal and vertical blanking. The frame geometry (dots per line, lines per frame and both blanking starts) is set by parameters, so one design covers the short-frame and long-frame variants.

Top module: `raster_irq_timer`

## Requirements
- R1: The horizontal position counts from 0 to H_DOTS-1 and advances by one on each clock with dot_en high. On wrapping to 0 it moves the vertical position on by one, and the vertical position wraps to 0 after V_LINES-1. With dot_en low, neither position changes.
- R2: Reading select 2 returns the blanking byte. Bit 7 is high while the line is at or past VBLANK_START, bit 6 is high while the dot is at or past HBLANK_START, and bits 5..0 are 0.
- R3: A dot_en clock at dot 0 of line VBLANK_START sets the frame flag, whatever the enables are. Reading select 0 returns that flag in bit 7, with VERSION in bits 3..0 and 0 in bits 6..4.
- R4: Reading select 0 clears the frame flag at the end of that clock. If the flag is set in the same clock, the set wins.
- R5: nmi_o is high exactly when the frame flag is set and enable bit 7 is 1.
- R6: Write select 0 loads the enable byte: bit 7 for the frame interrupt, bit 5 for the line match and bit 4 for the dot match. Selects 1 and 3 load bits 7..0 of the dot target and the line target. Selects 2 and 4 load bit 8 of those targets from data bit 0. A target beyond the frame never matches.
- R7: With only the dot-match enable set, a dot_en clock at a dot equal to the dot target sets the raster flag on every line.
- R8: With only the line-match enable set, the raster flag is set only by a dot_en clock at dot 0 of the line equal to the line target.
- R9: With both match enables set, the raster flag is set only when the dot and the line both equal their targets.
- R10: Reading select 1 returns the raster flag in bit 7, with bits 6..0 at 0. irq_o follows the flag and stays high until a read of select 1 clears it; a set in the same clock wins. With neither match enable set, the flag is never set.
- R11: After reset, both positions are 0, both flags are clear, the enable byte is 0 and both targets are 0x1FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Advance the position by one dot this clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 enable, 1/2 dot target low/high, 3/4 line target low/high |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Status read strobe; flags acknowledged at the end of the clock |
| rd_sel | input | 2 | Read select: 0 frame flag and version, 1 raster flag, 2 blanking |
| rd_data | output | 8 | Status byte for rd_sel (combinational) |
| nmi_o | output | 1 | Frame interrupt request |
| irq_o | output | 1 | Raster interrupt request |

## Verification
The raster interrupt is exercised in each enable pattern. Dot-only must fire on consecutive lines at the same dot, and line-only must fire at dot 0 of its line and nowhere else on that line. Dot-and-line must ignore a dot match on the wrong line and a line match at the wrong dot, and no enable must stay silent for a whole frame. A target whose bit 8 puts it past the line end must never fire until that bit is cleared, which separates the high-byte path from the low-byte path. The frame interrupt is tried with its enable off and on, and with a read landing in the same clock as the set.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

    localparam int POS_W = 9;

    localparam logic [2:0] WSEL_ENABLE = 3'd0;
    localparam logic [2:0] WSEL_HT_LO  = 3'd1;
    localparam logic [2:0] WSEL_HT_HI  = 3'd2;
    localparam logic [2:0] WSEL_VT_LO  = 3'd3;
    localparam logic [2:0] WSEL_VT_HI  = 3'd4;

    localparam logic [1:0] RSEL_FRAME  = 2'd0;
    localparam logic [1:0] RSEL_RASTER = 2'd1;
    localparam logic [1:0] RSEL_BLANK  = 2'd2;

    localparam int EN_FRAME_BIT = 7;
    localparam int EN_LINE_BIT  = 5;
    localparam int EN_DOT_BIT   = 4;

    typedef struct packed {
        logic             frame_en;
        logic             line_en;
        logic             dot_en;
        logic [POS_W-1:0] dot_tgt;
        logic [POS_W-1:0] line_tgt;
        logic             frame_flag;
        logic             raster_flag;
    } ctl_t;

endpackage

// File: rtl/raster_pos_counter.sv
module raster_pos_counter #(
    parameter int H_DOTS  = 340,
    parameter int V_LINES = 262,
    parameter int W       = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] h_o,
    output logic [W-1:0] v_o
);
    localparam logic [W-1:0] H_LAST = W'(H_DOTS - 1);
    localparam logic [W-1:0] V_LAST = W'(V_LINES - 1);

    typedef struct packed {
        logic [W-1:0] h;
        logic [W-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (tick) begin
            if (pos_q.h == H_LAST) begin
                pos_d.h = '0;
                pos_d.v = (pos_q.v == V_LAST) ? '0 : pos_q.v + 1'b1;
            end else begin
                pos_d.h = pos_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign h_o = pos_q.h;
    assign v_o = pos_q.v;
endmodule

// File: rtl/raster_event_decode.sv
module raster_event_decode #(
    parameter int VBLANK_START = 225,
    parameter int HBLANK_START = 274,
    parameter int W            = 9
) (
    input  logic [W-1:0] h,
    input  logic [W-1:0] v,
    input  logic [W-1:0] dot_tgt,
    input  logic [W-1:0] line_tgt,
    input  logic         dot_match_en,
    input  logic         line_match_en,
    output logic         frame_hit,
    output logic         raster_hit,
    output logic         hblank,
    output logic         vblank
);
    localparam logic [W-1:0] VBL = W'(VBLANK_START);
    localparam logic [W-1:0] HBL = W'(HBLANK_START);

    logic dot_eq, line_eq, at_line_start;

    always_comb begin
        dot_eq        = (h == dot_tgt);
        line_eq       = (v == line_tgt);
        at_line_start = (h == '0);
        frame_hit     = at_line_start && (v == VBL);
        hblank        = (h >= HBL);
        vblank        = (v >= VBL);
        case ({line_match_en, dot_match_en})
            2'b01:   raster_hit = dot_eq;
            2'b10:   raster_hit = line_eq && at_line_start;
            2'b11:   raster_hit = line_eq && dot_eq;
            default: raster_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/raster_irq_timer.sv
module raster_irq_timer
    import raster_irq_pkg::*;
#(
    parameter int         H_DOTS       = 340,
    parameter int         V_LINES      = 262,
    parameter int         VBLANK_START = 225,
    parameter int         HBLANK_START = 274,
    parameter logic [3:0] VERSION      = 4'h2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dot_en,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       nmi_o,
    output logic       irq_o
);
    logic [POS_W-1:0] h_pos, v_pos;
    logic frame_hit, raster_hit, hblank, vblank;
    logic nmi_flag, nmi_en;
    ctl_t s_d, s_q;

    raster_pos_counter #(
        .H_DOTS (H_DOTS),
        .V_LINES(V_LINES),
        .W      (POS_W)
    ) u_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (dot_en),
        .h_o  (h_pos),
        .v_o  (v_pos)
    );

    raster_event_decode #(
        .VBLANK_START(VBLANK_START),
        .HBLANK_START(HBLANK_START),
        .W           (POS_W)
    ) u_dec (
        .h            (h_pos),
        .v            (v_pos),
        .dot_tgt      (s_q.dot_tgt),
        .line_tgt     (s_q.line_tgt),
        .dot_match_en (s_q.dot_en),
        .line_match_en(s_q.line_en),
        .frame_hit    (frame_hit),
        .raster_hit   (raster_hit),
        .hblank       (hblank),
        .vblank       (vblank)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_sel)
                WSEL_ENABLE: begin
                    s_d.frame_en = wr_data[EN_FRAME_BIT];
                    s_d.line_en  = wr_data[EN_LINE_BIT];
                    s_d.dot_en   = wr_data[EN_DOT_BIT];
                end
                WSEL_HT_LO: s_d.dot_tgt[7:0]  = wr_data;
                WSEL_HT_HI: s_d.dot_tgt[8]    = wr_data[0];
                WSEL_VT_LO: s_d.line_tgt[7:0] = wr_data;
                WSEL_VT_HI: s_d.line_tgt[8]   = wr_data[0];
                default: ;
            endcase
        end
        if (rd_en && rd_sel == RSEL_FRAME)  s_d.frame_flag  = 1'b0;
        if (rd_en && rd_sel == RSEL_RASTER) s_d.raster_flag = 1'b0;
        if (dot_en && frame_hit)  s_d.frame_flag  = 1'b1;
        if (dot_en && raster_hit) s_d.raster_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.dot_tgt  <= '1;
            s_q.line_tgt <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (rd_sel)
            RSEL_FRAME:  rd_data = {s_q.frame_flag, 3'b000, VERSION};
            RSEL_RASTER: rd_data = {s_q.raster_flag, 7'b0};
            RSEL_BLANK:  rd_data = {vblank, hblank, 6'b0};
            default:     rd_data = 8'h00;
        endcase
    end

    assign nmi_flag = s_q.frame_flag;
    assign nmi_en   = s_q.frame_en;
    assign nmi_o    = nmi_flag && nmi_en;
    assign irq_o    = s_q.raster_flag;
endmodule

// File: rtl/raster_irq_timer_chk.sv
module raster_irq_timer_chk #(
    parameter int H_DOTS       = 340,
    parameter int V_LINES      = 262,
    parameter int VBLANK_START = 225
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dot_en,
    input logic       rd_en,
    input logic [1:0] rd_sel,
    input logic [7:0] rd_data,
    input logic       nmi_o,
    input logic       irq_o,
    input logic [8:0] h_pos,
    input logic [8:0] v_pos,
    input logic       nmi_flag,
    input logic       nmi_en
);
    localparam logic [8:0] H_LAST = 9'(H_DOTS - 1);
    localparam logic [8:0] V_LAST = 9'(V_LINES - 1);
    localparam logic [8:0] VBL    = 9'(VBLANK_START);

    AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        h_pos <= H_LAST); // R1
    AST_V_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        v_pos <= V_LAST); // R1
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> $stable(h_pos) && $stable(v_pos)); // R1
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        dot_en && h_pos == H_LAST |=> h_pos == 9'd0); // R1
    AST_BLANK_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_sel == 2'd2 |-> rd_data[5:0] == 6'd0); // R2
    AST_FRAME_AT_VBL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_flag) |-> $past(dot_en) && $past(h_pos) == 9'd0 && $past(v_pos) == VBL); // R3
    AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> nmi_en); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !(rd_en && rd_sel == 2'd1) |=> irq_o); // R10
    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_sel == 2'd1 && !dot_en |=> !irq_o); // R10
endmodule

bind raster_irq_timer raster_irq_timer_chk #(
    .H_DOTS      (H_DOTS),
    .V_LINES     (V_LINES),
    .VBLANK_START(VBLANK_START)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dot_en  (dot_en),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .nmi_o   (nmi_o),
    .irq_o   (irq_o),
    .h_pos   (h_pos),
    .v_pos   (v_pos),
    .nmi_flag(nmi_flag),
    .nmi_en  (nmi_en)
);

// File: tb/test_raster_irq_timer.sv
module test_raster_irq_timer;
    localparam int         TB_H   = 20;
    localparam int         TB_V   = 12;
    localparam int         TB_VBL = 9;
    localparam int         TB_HBL = 16;
    localparam logic [3:0] TB_VER = 4'h2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dot_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       nmi_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int hpos = 0;
    int vpos = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    raster_irq_timer #(
        .H_DOTS      (TB_H),
        .V_LINES     (TB_V),
        .VBLANK_START(TB_VBL),
        .HBLANK_START(TB_HBL),
        .VERSION     (TB_VER)
    ) i_raster_irq_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .dot_en (dot_en),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_sel (rd_sel),
        .rd_data(rd_data),
        .nmi_o  (nmi_o),
        .irq_o  (irq_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic adv_model();
        hpos++;
        if (hpos == TB_H) begin
            hpos = 0;
            vpos = (vpos == TB_V - 1) ? 0 : vpos + 1;
        end
    endtask

    task automatic step();
        dot_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dot_en = 1'b0;
        adv_model();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic go_to(input int h, input int v);
        for (int i = 0; i < TB_H * TB_V + 1; i++) begin
            if (hpos == h && vpos == v) break;
            step();
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] val);
        rd_en = 1'b1; rd_sel = sel;
        #1 val = rd_data;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic step_rd(input logic [1:0] sel, output logic [7:0] val);
        rd_en = 1'b1; rd_sel = sel; dot_en = 1'b1;
        #1 val = rd_data;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; dot_en = 1'b0;
        adv_model();
    endtask

    task automatic t_reset();
        chk(nmi_o == 1'b0, "R11 nmi_o after reset", nmi_o, 0);
        chk(irq_o == 1'b0, "R11 irq_o after reset", irq_o, 0);
        rd(2'd0, rv); chk(rv == {4'h0, TB_VER}, "R11/R3 frame status after reset", rv, {4'h0, TB_VER});
        rd(2'd1, rv); chk(rv == 8'h00, "R11 raster status after reset", rv, 0);
        rd(2'd2, rv); chk(rv == 8'h00, "R11 blank status at origin", rv, 0);
    endtask

    task automatic t_blank();
        go_to(TB_HBL - 1, 0);
        idle(30);
        rd(2'd2, rv); chk(rv == 8'h00, "R2 before hblank", rv, 0);
        step();
        rd(2'd2, rv); chk(rv == 8'h40, "R1 R2 hblank after idle hold", rv, 8'h40);
        go_to(TB_H - 1, TB_VBL - 1);
        rd(2'd2, rv); chk(rv == 8'h40, "R2 last dot before vblank", rv, 8'h40);
        step();
        rd(2'd2, rv); chk(rv == 8'h80, "R1 R2 wrap into vblank line", rv, 8'h80);
        go_to(TB_HBL, TB_VBL);
        rd(2'd2, rv); chk(rv == 8'hC0, "R2 both blanks", rv, 8'hC0);
        go_to(TB_H - 1, TB_V - 1);
        step();
        rd(2'd2, rv); chk(rv == 8'h00, "R1 frame wrap to origin", rv, 0);
    endtask

    task automatic t_frame();
        rd(2'd0, rv);
        wr(3'd0, 8'h00);
        go_to(0, TB_VBL);
        step();
        chk(nmi_o == 1'b0, "R5 nmi_o low with enable off", nmi_o, 0);
        rd(2'd0, rv); chk(rv == {4'h8, TB_VER}, "R3 flag set with enable off", rv, {4'h8, TB_VER});
        rd(2'd0, rv); chk(rv == {4'h0, TB_VER}, "R4 flag cleared by read", rv, {4'h0, TB_VER});
        wr(3'd0, 8'h80);
        go_to(0, TB_VBL);
        chk(nmi_o == 1'b0, "R3 no frame event before vblank line", nmi_o, 0);
        step();
        chk(nmi_o == 1'b1, "R5 nmi_o at vblank start", nmi_o, 1);
        rd(2'd0, rv); chk(rv == {4'h8, TB_VER}, "R3 status with enable on", rv, {4'h8, TB_VER});
        chk(nmi_o == 1'b0, "R4 nmi_o drops after read", nmi_o, 0);
        go_to(0, TB_VBL);
        step_rd(2'd0, rv);
        chk(nmi_o == 1'b1, "R4 set wins over same-clock read", nmi_o, 1);
        rd(2'd0, rv);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_dot_only();
        wr(3'd1, 8'd5); wr(3'd2, 8'd0);
        go_to(5, 1);
        rd(2'd1, rv);
        wr(3'd0, 8'h10);
        chk(irq_o == 1'b0, "R7 irq idle before dot match", irq_o, 0);
        step();
        chk(irq_o == 1'b1, "R7 dot match fires", irq_o, 1);
        rd(2'd1, rv); chk(rv == 8'h80, "R10 raster status byte", rv, 8'h80);
        chk(irq_o == 1'b0, "R10 irq cleared by read", irq_o, 0);
        go_to(5, 2);
        chk(irq_o == 1'b0, "R7 no fire between matches", irq_o, 0);
        step();
        chk(irq_o == 1'b1, "R7 fires again next line", irq_o, 1);
        step(); step(); step();
        chk(irq_o == 1'b1, "R10 irq held until read", irq_o, 1);
        rd(2'd1, rv);
    endtask

    task automatic t_line_only();
        wr(3'd0, 8'h00);
        wr(3'd3, 8'd3); wr(3'd4, 8'd0);
        go_to(TB_H - 1, 2);
        rd(2'd1, rv);
        wr(3'd0, 8'h20);
        step();
        chk(irq_o == 1'b0, "R8 last dot of prior line silent", irq_o, 0);
        step();
        chk(irq_o == 1'b1, "R8 fires at dot 0 of target line", irq_o, 1);
        rd(2'd1, rv);
        go_to(0, 4);
        chk(irq_o == 1'b0, "R8 rest of target line silent", irq_o, 0);
    endtask

    task automatic t_both();
        wr(3'd0, 8'h00);
        wr(3'd1, 8'd7); wr(3'd3, 8'd4);
        rd(2'd1, rv);
        wr(3'd0, 8'h30);
        step();
        chk(irq_o == 1'b0, "R9 line match alone silent", irq_o, 0);
        go_to(7, 4);
        chk(irq_o == 1'b0, "R9 silent before joint match", irq_o, 0);
        step();
        chk(irq_o == 1'b1, "R9 joint match fires", irq_o, 1);
        rd(2'd1, rv);
        go_to(7, 5);
        step();
        chk(irq_o == 1'b0, "R9 dot match on wrong line silent", irq_o, 0);
    endtask

    task automatic t_high_bit();
        wr(3'd0, 8'h00);
        wr(3'd1, 8'd2); wr(3'd2, 8'h01);
        go_to(0, 6);
        rd(2'd1, rv);
        wr(3'd0, 8'h10);
        go_to(0, 7);
        chk(irq_o == 1'b0, "R6 target with bit 8 set never matches", irq_o, 0);
        wr(3'd2, 8'h00);
        go_to(2, 7);
        chk(irq_o == 1'b0, "R6 silent before low target", irq_o, 0);
        step();
        chk(irq_o == 1'b1, "R6 bit 8 cleared target fires", irq_o, 1);
        rd(2'd1, rv);
    endtask

    task automatic t_none();
        wr(3'd0, 8'h00);
        for (int i = 0; i < TB_H * TB_V; i++) step();
        chk(irq_o == 1'b0, "R10 no enable never fires", irq_o, 0);
        rd(2'd1, rv); chk(rv == 8'h00, "R10 status clear with no enable", rv, 0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_blank();
        t_frame();
        t_dot_only();
        t_line_only();
        t_both();
        t_high_bit();
        t_none();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule